// File: doc/BRIEF.md
# Indexed Colour Palette Loader and Lookup

This block holds a 256-entry colour table of 12-bit RGB 4:4:4 values and uses it to turn 8-bit indexed pixels into colour. Palette words arrive on a valid/ready stream. Each accepted word fills the next table entry. The top nibble of the first word of a load also names the pixel depth. That depth fixes how many words the load expects, and it chooses between table lookup and direct pass-through of 16-bit pixels.

A 2-bit load-mode input is sampled when `enable` rises. One mode fetches only the palette and then raises a loaded-palette status. Another fetches the palette and then moves straight to pixel translation. A third skips the palette and translates pixels with whatever table and format are already held. Dropping `enable` returns the block to idle and clears the status.

Pixels enter on their own valid/ready stream. The translated result leaves one clock later with a matching valid flag. The output has no back-pressure.

Top module: `pal_lut_top`

## Requirements
- R1: After reset, `pal_ready`, `pix_ready`, `out_valid` and `pal_loaded` are all low.
- R2: When `enable` rises with `load_mode` 2'b00 (palette then frame) or 2'b01 (palette only), `pal_ready` goes high on the next cycle. The k-th accepted word writes its bits 11:0 into entry k, with red in 11:8, green in 7:4 and blue in 3:0. `pix_ready` stays low during the load.
- R3: Bits 15:12 of the first word of a load are held on `fmt_code`. Code 3 (8 bpp) expects 256 words. Code 4 (12/16 bpp) and codes 5 to 15 expect 16 words. Codes 0, 1 and 2 (1, 2, 4 bpp) expect 128 words. The top nibble of later words is not used.
- R4: In mode 2'b01, after the last expected word `pal_loaded` is high, and both `pal_ready` and `pix_ready` are low.
- R5: In mode 2'b01, a one on `pal_loaded_clr` clears `pal_loaded` on the next cycle.
- R6: In mode 2'b00, after the last expected word `pal_loaded` is high and `pix_ready` is high. `pal_loaded_clr` has no effect on `pal_loaded` in this mode.
- R7: In mode 2'b10 (frame only), and in 2'b11, `pix_ready` is high from the cycle after `enable` rises and `pal_ready` stays low. Palette words offered then are not taken, and the table and `fmt_code` keep their values.
- R8: For a format code other than 4, a pixel accepted at one edge yields `out_valid` high and `out_data` = {4'b0, entry[pix_data[7:0]]} after the next edge. Without an accepted pixel, `out_valid` is low.
- R9: With format code 4, an accepted pixel passes through unchanged: `out_data` equals `pix_data` one cycle later.
- R10: With `enable` low, the block is idle on the next cycle: both ready outputs and `pal_loaded` are low. The next rise of `enable` samples `load_mode` afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; a rise starts a load or frame pass |
| load_mode | input | 2 | 00 palette then frame, 01 palette only, 10/11 frame only |
| pal_valid | input | 1 | Palette word offered |
| pal_ready | output | 1 | Palette word taken this cycle when valid |
| pal_data | input | 16 | Palette word: format code 15:12 (first word), RGB 11:0 |
| pal_loaded_clr | input | 1 | Write-one clear of the loaded status (palette-only mode) |
| pal_loaded | output | 1 | Palette load finished |
| fmt_code | output | 4 | Format code captured from the first palette word |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel taken this cycle when valid |
| pix_data | input | 16 | Pixel: index in 7:0, or a full 16-bit value in direct mode |
| out_valid | output | 1 | Translated pixel present |
| out_data | output | 16 | Translated pixel |

## Verification
Control outputs such as `pal_ready`, `pix_ready`, `pal_loaded` and `fmt_code` change at the edge that takes the triggering word or sees `enable` change. The bench therefore reads them at the falling edge that follows. A translated pixel appears one edge after the pixel is taken. The bench's driver queues the expected value when it offers the pixel, and its monitor compares every `out_valid` beat at the next falling edge. An empty queue at the end shows that no beat was dropped, and a beat arriving with nothing queued counts as a failure.

// File: rtl/pal_pkg.sv
// Package: shared phase type, load-mode codes and the format-to-length rule
// for the palette loader. Assumes 8-bit indices (256-entry table).
package pal_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_FRAME = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;

    localparam logic [1:0] LM_BOTH  = 2'b00;
    localparam logic [1:0] LM_PAL   = 2'b01;
    localparam logic [3:0] FMT_DIRECT = 4'd4;

    // Number of palette words a load expects for a given format code.
    function automatic logic [8:0] words_for_code(input logic [3:0] code);
        case (code)
            4'd0, 4'd1, 4'd2: words_for_code = 9'd128;
            4'd3:             words_for_code = 9'd256;
            default:          words_for_code = 9'd16;
        endcase
    endfunction

endpackage

// File: rtl/pal_seq.sv
// Sequencer: samples the load mode when enable rises, counts palette words,
// captures the format code from the first word and owns the loaded status.
// Assumes enable stays high for the whole pass; dropping it aborts.
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       load_mode,
    input  logic             pal_valid,
    input  logic [3:0]       pal_code,
    input  logic             pal_loaded_clr,
    output logic             pal_ready,
    output logic             pix_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [3:0]       fmt_code,
    output logic             pal_loaded
);
    localparam int CNT_W = IDX_W + 1;

    phase_t           phase;
    logic [1:0]       mode_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] need_now;
    logic             accept;
    logic             last;

    // Word acceptance and end-of-load detection.
    always_comb begin
        accept   = (phase == PH_LOAD) && pal_valid;
        need_now = (cnt == '0) ? CNT_W'(words_for_code(pal_code)) : need;
        last     = accept && ((cnt + 1'b1) == need_now);
    end

    assign pal_ready = (phase == PH_LOAD);
    assign pix_ready = (phase == PH_FRAME);
    assign wr_en     = accept;
    assign wr_addr   = cnt[IDX_W-1:0];

    // Phase, counter, format and status state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            mode_q     <= LM_BOTH;
            cnt        <= '0;
            need       <= '0;
            fmt_code   <= '0;
            pal_loaded <= 1'b0;
        end else if (!enable) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            pal_loaded <= 1'b0;
        end else begin
            if (mode_q == LM_PAL && pal_loaded_clr && phase != PH_IDLE)
                pal_loaded <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    mode_q <= load_mode;
                    cnt    <= '0;
                    phase  <= (load_mode == LM_PAL || load_mode == LM_BOTH)
                              ? PH_LOAD : PH_FRAME;
                end
                PH_LOAD: begin
                    if (accept) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == '0) begin
                            fmt_code <= pal_code;
                            need     <= need_now;
                        end
                    end
                    if (last) begin
                        pal_loaded <= 1'b1;
                        phase      <= (mode_q == LM_PAL) ? PH_DONE : PH_FRAME;
                    end
                end
                default: phase <= phase;
            endcase
        end
    end

endmodule

// File: rtl/pal_lut.sv
// Colour table and registered output stage. Writes one entry per cycle;
// reads with one cycle of latency, or passes the pixel straight through
// when bypass is set. Table contents are not reset.
module pal_lut #(
    parameter int IDX_W = 8,
    parameter int COL_W = 12,
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [COL_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [PIX_W-1:0] pix,
    input  logic             bypass,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [COL_W-1:0] mem [DEPTH];
    logic [PIX_W-1:0] looked_up;

    // Table write port.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Widen the stored colour to the pixel width.
    generate
        if (PIX_W > COL_W) begin : g_pad
            assign looked_up = {{(PIX_W-COL_W){1'b0}}, mem[pix[IDX_W-1:0]]};
        end else begin : g_trim
            assign looked_up = mem[pix[IDX_W-1:0]][PIX_W-1:0];
        end
    endgenerate

    // Registered result with aligned valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rd_en;
            if (rd_en)
                out_data <= bypass ? pix : looked_up;
        end
    end

endmodule

// File: rtl/pal_lut_top.sv
// Top: palette loader plus indexed-pixel lookup. The first word of a load
// carries the format code; later words only carry colour.
module pal_lut_top
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COL_W  = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        load_mode,
    input  logic              pal_valid,
    output logic              pal_ready,
    input  logic [WORD_W-1:0] pal_data,
    input  logic              pal_loaded_clr,
    output logic              pal_loaded,
    output logic [3:0]        fmt_code,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [WORD_W-1:0] pix_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .load_mode      (load_mode),
        .pal_valid      (pal_valid),
        .pal_code       (pal_data[WORD_W-1 -: 4]),
        .pal_loaded_clr (pal_loaded_clr),
        .pal_ready      (pal_ready),
        .pix_ready      (pix_ready),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .fmt_code       (fmt_code),
        .pal_loaded     (pal_loaded)
    );

    pal_lut #(.IDX_W(IDX_W), .COL_W(COL_W), .PIX_W(WORD_W)) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (pal_data[COL_W-1:0]),
        .rd_en     (pix_valid && pix_ready),
        .pix       (pix_data),
        .bypass    (fmt_code == FMT_DIRECT),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/pal_lut_chk.sv
// Checker: temporal properties of the palette loader's ports.
module pal_lut_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              pal_ready,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic [WORD_W-1:0] pix_data,
    input logic [3:0]        fmt_code,
    input logic              pal_loaded,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data
);
    p_ready_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pal_ready && pix_ready));

    p_out_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> out_valid);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && pix_ready) |=> !out_valid);

    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && fmt_code == 4'd4) |=> (out_data == $past(pix_data)));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pal_loaded && !pal_ready && !pix_ready));

endmodule

bind pal_lut_top pal_lut_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .pal_ready  (pal_ready),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix_data   (pix_data),
    .fmt_code   (fmt_code),
    .pal_loaded (pal_loaded),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/pal_lut_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected pixels, a monitor compares.
module pal_lut_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  load_mode = 2'b00;
    logic        pal_valid = 1'b0;
    logic        pal_ready;
    logic [15:0] pal_data = '0;
    logic        pal_loaded_clr = 1'b0;
    logic        pal_loaded;
    logic [3:0]  fmt_code;
    logic        pix_valid = 1'b0;
    logic        pix_ready;
    logic [15:0] pix_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    logic [11:0] exp_pal [256];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    pal_lut_top u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .load_mode(load_mode),
        .pal_valid(pal_valid), .pal_ready(pal_ready), .pal_data(pal_data),
        .pal_loaded_clr(pal_loaded_clr), .pal_loaded(pal_loaded),
        .fmt_code(fmt_code), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ent(int i, int seed);
        return 12'((i * 53 + seed * 311) ^ (i << 5));
    endfunction

    // Monitor: compare every output beat with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 actual %h expected none", out_data);
            end else begin
                chk(tag_q.pop_front(), 32'(out_data), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic start(logic [1:0] m);
        @(negedge clk); load_mode = m; enable = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic stop();
        @(negedge clk); enable = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic load_words(logic [3:0] code, int first, int last, int seed);
        for (int i = first; i <= last; i++) begin
            @(negedge clk);
            if (!pal_ready) begin
                checks++; errors++;
                $display("FAIL R2 actual pal_ready 0 expected 1 at word %0d", i);
            end
            exp_pal[i] = ent(i, seed);
            pal_data   = {(i == 0) ? code : 4'h3, exp_pal[i]};
            pal_valid  = 1'b1;
            @(posedge clk); #1;
            pal_valid  = 1'b0;
        end
    endtask

    task automatic send_pix(logic [15:0] p, logic [15:0] e, string req);
        @(negedge clk);
        pix_valid = 1'b1; pix_data = p;
        exp_q.push_back(e); tag_q.push_back(req);
        @(posedge clk); #1;
        pix_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); pal_loaded_clr = 1'b1;
        @(posedge clk); #1; pal_loaded_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {30'd0, pal_ready, pix_ready}, 32'd0);
        chk("R1 out", {30'd0, out_valid, pal_loaded}, 32'd0);

        // Palette then frame, 8 bpp.
        start(2'b00);
        @(negedge clk);
        chk("R2 ready", {30'd0, pal_ready, pix_ready}, 32'b10);
        load_words(4'd3, 0, 255, 1);
        @(negedge clk);
        chk("R6 loaded", 32'(pal_loaded), 32'd1);
        chk("R6 ready", {30'd0, pal_ready, pix_ready}, 32'b01);
        chk("R3 fmt 3", 32'(fmt_code), 32'd3);
        send_pix(16'h0000, {4'b0, exp_pal[0]}, "R8 idx0");
        send_pix(16'h00FF, {4'b0, exp_pal[255]}, "R8 idx255");
        send_pix(16'hAB12, {4'b0, exp_pal[8'h12]}, "R8 idx12");
        send_pix(16'h004D, {4'b0, exp_pal[8'h4D]}, "R2 entry");
        pulse_clr();
        @(negedge clk);
        chk("R6 clr ignored", 32'(pal_loaded), 32'd1);
        stop();
        @(negedge clk);
        chk("R10 idle", {29'd0, pal_loaded, pal_ready, pix_ready}, 32'd0);

        // Palette only, 4 bpp: 128 words.
        start(2'b01);
        load_words(4'd2, 0, 126, 2);
        @(negedge clk);
        chk("R3 count", {30'd0, pal_loaded, pal_ready}, 32'b01);
        load_words(4'd2, 127, 127, 2);
        @(negedge clk);
        chk("R4 loaded", 32'(pal_loaded), 32'd1);
        chk("R4 ready", {30'd0, pal_ready, pix_ready}, 32'd0);
        chk("R3 fmt 2", 32'(fmt_code), 32'd2);
        pulse_clr();
        @(negedge clk);
        chk("R5 clr", 32'(pal_loaded), 32'd0);
        stop();

        // Frame only: offered palette words are refused.
        start(2'b10);
        @(negedge clk);
        chk("R7 ready", {30'd0, pal_ready, pix_ready}, 32'b01);
        pal_data = 16'h4FFF; pal_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1 pal_valid = 1'b0;
        @(negedge clk);
        chk("R7 fmt kept", 32'(fmt_code), 32'd2);
        send_pix(16'h0000, {4'b0, exp_pal[0]}, "R7 entry0");
        send_pix(16'h00C8, {4'b0, exp_pal[200]}, "R7 entry200");
        stop();

        // Palette then frame, direct format: 16 words then bypass.
        start(2'b00);
        load_words(4'd4, 0, 15, 3);
        @(negedge clk);
        chk("R3 fmt 4", 32'(fmt_code), 32'd4);
        chk("R3 len16", {30'd0, pal_ready, pix_ready}, 32'b01);
        send_pix(16'hBEEF, 16'hBEEF, "R9 pass");
        send_pix(16'h0003, 16'h0003, "R9 pass low");
        repeat (3) @(negedge clk);
        chk("R8 drained", 32'(exp_q.size()), 32'd0);
        stop();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule